// File: doc/BRIEF.md
# Free-running tick timer with periodic interrupt

The block is a free-running timer peripheral controlled through one 8-bit register. A binary count advances once per operating clock. Its low eight bits form a byte counter. When that byte wraps from 0xFF to 0x00, the block raises a wrap flag. The higher bits of the same count act as a fixed divide-by-8192 prescaler followed by three further binary stages. A 2-bit rate field picks one of four taps from these stages, and each rising edge of the chosen tap raises a periodic flag.

Each flag has its own enable bit. Each flag-and-enable pair drives its own registered interrupt request. Software reads both flags from the register. Because the flags cannot be written directly, software clears them by writing 1 to two dedicated bits that always read back as 0.

Top module: `irq_tick_timer`

## Requirements
- R1: After reset the register reads 0x03 (rate field 11, all flags and enables 0) and both interrupt requests are low.
- R2: The wrap flag (bit 7) is set on the clock edge where the byte counter goes from 0xFF to 0x00. That edge is the 256th edge after reset and every 256th edge after that.
- R3: The periodic flag (bit 6) is set on each rising edge of free-count bit 12+sel, where sel is the rate field in bits 1:0. The first set is 2^(12+sel) edges after reset, and later sets follow every 2^(13+sel) edges. The reset value sel=3 gives a period of 65536 clocks.
- R4: A write that changes the rate field never sets the periodic flag on that edge or the next one unless a true rising edge of the newly selected tap occurs.
- R5: Writing 1 to bit 5 clears the wrap flag, and writing 1 to bit 4 clears the periodic flag. Writing 0 to either bit leaves the flag unchanged.
- R6: When a flag-setting event and a clear write land on the same edge, the flag ends up set.
- R7: The wrap request is high exactly when the wrap flag and its enable (bit 3) are both 1. The periodic request is high exactly when the periodic flag and its enable (bit 2) are both 1. Both requests change on the same edge as the flag or enable that drives them.
- R8: A read returns {wrap flag, periodic flag, 0, 0, wrap enable, periodic enable, rate[1:0]}. Only bits 3:0 are stored by a write.
- R9: A write to any address other than the register address has no effect, and a read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| ovf_irq_o | output | 1 | Wrap interrupt request |
| per_irq_o | output | 1 | Periodic interrupt request |

## Verification
Each flag, enable and request becomes visible on the same clock edge that its cause takes effect, and read data follows the address with no clock delay. A write therefore shows its result just after the edge that samples the strobe. The bench counts edges since reset release. It checks the flags at both edge N-1 and edge N around each predicted event, so an off-by-one in the count or in the tap choice is caught. It times the combined set-and-clear case and the rate switch to fall on exactly predicted edges, and it samples 1 ns after the edge or at the falling edge.

// File: rtl/itt_pkg.sv
package itt_pkg;
  localparam int DATA_W   = 8;
  localparam int RATE_W   = 2;
  localparam int TAPS     = 1 << RATE_W;
  localparam int BIT_OVF  = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_CLRO = 5;
  localparam int BIT_CLRP = 4;
  localparam int BIT_OEN  = 3;
  localparam int BIT_PEN  = 2;

  typedef struct packed {
    logic              ovf_en;
    logic              per_en;
    logic [RATE_W-1:0] rate;
  } itt_cfg_t;

  localparam itt_cfg_t CFG_RST = '{ovf_en: 1'b0, per_en: 1'b0, rate: '1};
endpackage

// File: rtl/itt_chain.sv
module itt_chain #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + 1'b1;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/itt_tap_edge.sv
module itt_tap_edge #(
  parameter int W        = 16,
  parameter int TAP_BASE = 12,
  parameter int TAPS     = 4,
  parameter int SEL_W    = 2
) (
  input  logic [W-1:0]     cnt_i,
  input  logic [W-1:0]     cnt_nxt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o
);
  logic [TAPS-1:0] tap_now, tap_nxt;

  for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
    assign tap_now[gi] = cnt_i[TAP_BASE + gi];
    assign tap_nxt[gi] = cnt_nxt_i[TAP_BASE + gi];
  end

  // both sides use the same selection, so a selection change alone cannot form an edge
  assign rise_o = tap_nxt[sel_i] & ~tap_now[sel_i];
endmodule

// File: rtl/itt_regs.sv
module itt_regs
  import itt_pkg::*;
#(
  parameter int AW       = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              ovf_evt_i,
  input  logic              per_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output itt_cfg_t          cfg_o,
  output logic              tof_o,
  output logic              rtif_o,
  output logic              ovf_irq_o,
  output logic              per_irq_o
);
  logic     hit_rd, hit_wr;
  logic     tof_q, rtif_q, tof_d, rtif_d;
  itt_cfg_t cfg_q, cfg_d;

  assign hit_rd = (addr_i == AW'(REG_ADDR));
  assign hit_wr = wr_i & hit_rd;

  always_comb begin
    cfg_d  = cfg_q;
    tof_d  = tof_q;
    rtif_d = rtif_q;
    if (hit_wr) begin
      cfg_d.ovf_en = wdata_i[BIT_OEN];
      cfg_d.per_en = wdata_i[BIT_PEN];
      cfg_d.rate   = wdata_i[RATE_W-1:0];
      if (wdata_i[BIT_CLRO]) tof_d  = 1'b0;
      if (wdata_i[BIT_CLRP]) rtif_d = 1'b0;
    end
    if (ovf_evt_i) tof_d  = 1'b1;
    if (per_evt_i) rtif_d = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q     <= CFG_RST;
      tof_q     <= 1'b0;
      rtif_q    <= 1'b0;
      ovf_irq_o <= 1'b0;
      per_irq_o <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      tof_q     <= tof_d;
      rtif_q    <= rtif_d;
      ovf_irq_o <= tof_d & cfg_d.ovf_en;
      per_irq_o <= rtif_d & cfg_d.per_en;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_rd) begin
      rdata_o[BIT_OVF]      = tof_q;
      rdata_o[BIT_PER]      = rtif_q;
      rdata_o[BIT_OEN]      = cfg_q.ovf_en;
      rdata_o[BIT_PEN]      = cfg_q.per_en;
      rdata_o[RATE_W-1:0]   = cfg_q.rate;
    end
  end

  assign cfg_o  = cfg_q;
  assign tof_o  = tof_q;
  assign rtif_o = rtif_q;
endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
  import itt_pkg::*;
#(
  parameter int AW       = 4,
  parameter int REG_ADDR = 0,
  parameter int CNT_W    = 8,
  parameter int PRE_BITS = 13
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          wr_i,
  output logic [7:0]    rdata_o,
  output logic          ovf_irq_o,
  output logic          per_irq_o
);
  localparam int CHAIN_W  = PRE_BITS + TAPS - 1;
  localparam int TAP_BASE = PRE_BITS - 1;

  logic [CHAIN_W-1:0] chain_q, chain_nxt;
  logic               ovf_evt, per_evt;
  logic               tof_q, rtif_q;
  itt_cfg_t           cfg_q;

  itt_chain #(.W(CHAIN_W)) u_chain (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cnt_o     (chain_q),
    .cnt_nxt_o (chain_nxt)
  );

  assign ovf_evt = &chain_q[CNT_W-1:0];

  itt_tap_edge #(
    .W(CHAIN_W), .TAP_BASE(TAP_BASE), .TAPS(TAPS), .SEL_W(RATE_W)
  ) u_tap (
    .cnt_i     (chain_q),
    .cnt_nxt_i (chain_nxt),
    .sel_i     (cfg_q.rate),
    .rise_o    (per_evt)
  );

  itt_regs #(.AW(AW), .REG_ADDR(REG_ADDR)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_i      (wr_i),
    .ovf_evt_i (ovf_evt),
    .per_evt_i (per_evt),
    .rdata_o   (rdata_o),
    .cfg_o     (cfg_q),
    .tof_o     (tof_q),
    .rtif_o    (rtif_q),
    .ovf_irq_o (ovf_irq_o),
    .per_irq_o (per_irq_o)
  );
endmodule

// File: rtl/itt_chk.sv
module itt_chk
  import itt_pkg::*;
#(
  parameter int AW       = 4,
  parameter int REG_ADDR = 0,
  parameter int CNT_W    = 8,
  parameter int CHAIN_W  = 16,
  parameter int TAP_BASE = 12
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic [AW-1:0]      addr_i,
  input logic [7:0]         wdata_i,
  input logic               wr_i,
  input logic [CHAIN_W-1:0] chain_q,
  input itt_cfg_t           cfg_q,
  input logic               tof_q,
  input logic               rtif_q,
  input logic               ovf_irq_o,
  input logic               per_irq_o
);
  logic hit_wr;
  assign hit_wr = wr_i && (addr_i == AW'(REG_ADDR));

  // R6
  wrap_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (&chain_q[CNT_W-1:0]) |=> tof_q);

  // R2
  wrap_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(tof_q) |-> (chain_q[CNT_W-1:0] == '0));

  // R5
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hit_wr && wdata_i[BIT_CLRO] && !(&chain_q[CNT_W-1:0])) |=> !tof_q);

  // R3
  per_tap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(rtif_q) && $stable(cfg_q.rate)) |-> chain_q[TAP_BASE + int'(cfg_q.rate)]);

  // R7
  ovf_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_irq_o == (tof_q && cfg_q.ovf_en));

  // R7
  per_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    per_irq_o == (rtif_q && cfg_q.per_en));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit_wr |=> $stable(cfg_q));
endmodule

bind irq_tick_timer itt_chk #(
  .AW(AW), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W), .CHAIN_W(CHAIN_W), .TAP_BASE(TAP_BASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_i      (wr_i),
  .chain_q   (chain_q),
  .cfg_q     (cfg_q),
  .tof_q     (tof_q),
  .rtif_q    (rtif_q),
  .ovf_irq_o (ovf_irq_o),
  .per_irq_o (per_irq_o)
);

// File: tb/irq_tick_timer_test.sv
`timescale 1ns/1ps
module irq_tick_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0;
  logic [7:0] rdata;
  logic       ovf_irq, per_irq;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  irq_tick_timer uut (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rdata_o(rdata), .ovf_irq_o(ovf_irq), .per_irq_o(per_irq)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at edge %0d", req, act, exp, cyc);
    end
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
    addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // call at a falling edge; the write takes effect on the next rising edge
  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1;
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wait_cyc(input int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    read_chk("R1", 4'd0, 8'h03);
    check("R1", {6'd0, ovf_irq, per_irq}, 8'h00);
  endtask

  task automatic t_wrap();
    do_reset();
    wait_cyc(255);
    read_chk("R2", 4'd0, 8'h03);
    wait_cyc(256);
    read_chk("R2", 4'd0, 8'h83);
    reg_write(4'd0, 8'h03);                 // zero in bit 5: no clear
    read_chk("R5", 4'd0, 8'h83);
    check("R7", {7'd0, ovf_irq}, 8'h00);
    @(negedge clk);
    reg_write(4'd0, 8'h0B);                 // enable wrap request
    check("R7", {7'd0, ovf_irq}, 8'h01);
    @(negedge clk);
    reg_write(4'd0, 8'h2B);                 // clear wrap flag
    read_chk("R5", 4'd0, 8'h0B);
    check("R7", {7'd0, ovf_irq}, 8'h00);
    wait_cyc(511);
    read_chk("R2", 4'd0, 8'h0B);
    wait_cyc(512);
    read_chk("R2", 4'd0, 8'h8B);
    check("R7", {7'd0, ovf_irq}, 8'h01);
    wait_cyc(767);
    reg_write(4'd0, 8'h2B);                 // clear lands on the wrap edge
    read_chk("R6", 4'd0, 8'h8B);
    check("R6", {7'd0, ovf_irq}, 8'h01);
  endtask

  task automatic t_fast_rate();
    do_reset();
    reg_write(4'd0, 8'h00);                 // rate 0: tap bit 12
    wait_cyc(4095);
    read_chk("R3", 4'd0, 8'h80);            // wrap flag already set by now
    wait_cyc(4096);
    read_chk("R3", 4'd0, 8'hC0);
    check("R7", {7'd0, per_irq}, 8'h00);
    reg_write(4'd0, 8'h24);                 // enable periodic, clear wrap
    check("R7", {7'd0, per_irq}, 8'h01);
    @(negedge clk);
    reg_write(4'd0, 8'h14);                 // clear periodic flag
    read_chk("R5", 4'd0, 8'h04);
    check("R7", {7'd0, per_irq}, 8'h00);
    @(negedge clk);
    reg_write(4'd0, 8'h24);                 // clear wrap again
    wait_cyc(12287);
    read_chk("R3", 4'd0, 8'h84);
    wait_cyc(12288);
    read_chk("R3", 4'd0, 8'hC4);
  endtask

  task automatic t_slow_rate();
    do_reset();
    wait_cyc(32767);
    read_chk("R3", 4'd0, 8'h83);
    wait_cyc(32768);
    read_chk("R3", 4'd0, 8'hC3);
  endtask

  task automatic t_switch();
    do_reset();
    reg_write(4'd0, 8'h01);                 // rate 1: tap bit 13
    wait_cyc(6144);                         // bit 12 high, bit 13 low
    reg_write(4'd0, 8'h20);                 // rate 0, clear wrap
    read_chk("R4", 4'd0, 8'h00);
    @(negedge clk);
    read_chk("R4", 4'd0, 8'h00);
    wait_cyc(12287);
    reg_write(4'd0, 8'h20);
    read_chk("R4", 4'd0, 8'hC0);            // real edge of bit 12 at 12288
  endtask

  task automatic t_addr();
    do_reset();
    reg_write(4'd1, 8'h0D);
    read_chk("R9", 4'd0, 8'h03);
    read_chk("R9", 4'd1, 8'h00);
    @(negedge clk);
    reg_write(4'd0, 8'hFF);
    read_chk("R8", 4'd0, 8'h0F);
    @(negedge clk);
    reg_write(4'd0, 8'h06);
    read_chk("R8", 4'd0, 8'h06);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_fast_rate();
    t_slow_rate();
    t_switch();
    t_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired at edge %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule